// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides what a fused multiply-add `(a*b)+c` must return when one or more of its operands is a NaN, or when the product is infinity times zero. It does not classify or silence operands and does no arithmetic. An upstream classifier supplies a 2-bit class for each operand and a flag that marks the infinity-times-zero product. The block returns a 2-bit choice code that names operand a, operand b, operand c or the default NaN, together with an invalid-operation flag.

Four selection policies are supported, picked by the `policy` input. Policy 1 has two variants, chosen by `legacy_enc`, which gives the signaling-bit polarity of the NaN encoding in use. Each policy first resolves the infinity-times-zero case in its own way. Only then does it walk a fixed priority chain over the three operands.

A small two-state machine is the timing skeleton. In `ST_IDLE` no result is shown. Transition `T_ACCEPT` (in_valid high) goes to `ST_EMIT`. In `ST_EMIT`, `out_valid` is high for the result captured on that edge. `T_AGAIN` (in_valid high) stays in `ST_EMIT`, and `T_DRAIN` (in_valid low) returns to `ST_IDLE`. `T_IDLE_WAIT` (in_valid low in `ST_IDLE`) stays put. Reset enters `ST_IDLE`.

Top module: `fma_nan_sel`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Reset drives `out_valid`, `pick` and `invalid` to 0.
- R2: While `in_valid` is low, `pick` and `invalid` keep the value of the last accepted request.
- R3: Choice codes are 0 = a, 1 = b, 2 = c, 3 = default NaN. In policy 0 without the override, the first match wins in this order: c signaling, a signaling, b signaling, c quiet, a quiet. If none matches, the result is b.
- R4: In policy 0, infinity-times-zero together with a quiet c gives code 3 with `invalid` = 1. Infinity-times-zero with any other class of c sets no flag and follows the R3 chain.
- R5: In policy 1 with `legacy_enc` = 1 and no override, the first match wins in this order: a signaling, b signaling, c signaling, a quiet, b quiet. If none matches, the result is c.
- R6: In policy 1 with `legacy_enc` = 1, infinity-times-zero gives code 3 with `invalid` = 1, whatever the operand classes are.
- R7: In policy 1 with `legacy_enc` = 0 and no override, the first match wins in this order: c signaling, a signaling, b signaling, c quiet, a quiet. If none matches, the result is b.
- R8: In policy 1 with `legacy_enc` = 0, infinity-times-zero gives code 2 with `invalid` = 1.
- R9: In policy 2, infinity-times-zero gives code 2 with `invalid` = 1. Otherwise the result is a if a is any NaN, else c if c is any NaN, else b.
- R10: In policy 3, the infinity-times-zero flag has no effect and `invalid` stays 0. The result is a if a is any NaN, else b if b is any NaN, else c.
- R11: Class encoding per operand: 0 = not a NaN, 1 = quiet NaN, 2 = signaling NaN. Code 3 is treated as not a NaN.
- R12: `invalid` is 1 only for a request that has infinity-times-zero set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| cls_a | input | 2 | Class of multiplicand a (R11 encoding) |
| cls_b | input | 2 | Class of multiplier b |
| cls_c | input | 2 | Class of addend c |
| inf_zero | input | 1 | Product is infinity times zero |
| policy | input | 2 | Selection policy 0..3 |
| legacy_enc | input | 1 | 1 = legacy signaling polarity, 0 = 2008 polarity (policy 1 only) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| pick | output | 2 | Choice code: 0 a, 1 b, 2 c, 3 default NaN |
| invalid | output | 1 | Invalid-operation flag for the result |

## Verification
Every result is due on the first rising edge after the edge that accepted its request. The bench drives requests on falling edges. At the falling edge one cycle later, a monitor pops the matching expected entry from a queue and compares it with the outputs. Back-to-back requests therefore produce one comparison per cycle, and an `out_valid` with an empty queue counts as a failure. The hold and reset checks are made at falling edges with `in_valid` low, where nothing may change.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    // operand class codes
    localparam logic [1:0] CLS_NUM    = 2'd0;
    localparam logic [1:0] CLS_QUIET  = 2'd1;
    localparam logic [1:0] CLS_SIGNAL = 2'd2;

    // choice codes
    localparam logic [1:0] PICK_A    = 2'd0;
    localparam logic [1:0] PICK_B    = 2'd1;
    localparam logic [1:0] PICK_C    = 2'd2;
    localparam logic [1:0] PICK_DFLT = 2'd3;

    // slot test kinds
    localparam logic [1:0] TST_NONE  = 2'd0;
    localparam logic [1:0] TST_SIG   = 2'd1;
    localparam logic [1:0] TST_QUIET = 2'd2;
    localparam logic [1:0] TST_ANY   = 2'd3;

    localparam int SLOTS    = 5;
    localparam int N_ORDERS = 5;

    // priority orderings
    localparam int ORD_P0  = 0;
    localparam int ORD_P1L = 1;
    localparam int ORD_P1N = 2;
    localparam int ORD_P2  = 3;
    localparam int ORD_P3  = 4;

    // {test kind, operand} for one slot of one ordering
    function automatic logic [3:0] slot_rule(input int ord, input int slot);
        logic [1:0] tst;
        logic [1:0] opn;
        tst = TST_NONE;
        opn = PICK_A;
        if (ord == ORD_P2 || ord == ORD_P3) begin
            if (slot < 2) begin
                tst = TST_ANY;
                opn = (slot == 0) ? PICK_A : ((ord == ORD_P2) ? PICK_C : PICK_B);
            end
        end else begin
            tst = (slot < 3) ? TST_SIG : TST_QUIET;
            case (slot % 3)
                0:       opn = (ord == ORD_P1L) ? PICK_A : PICK_C;
                1:       opn = (ord == ORD_P1L) ? PICK_B : PICK_A;
                default: opn = (ord == ORD_P1L) ? PICK_C : PICK_B;
            endcase
        end
        return {tst, opn};
    endfunction

    function automatic logic [1:0] fallback_of(input int ord);
        return (ord == ORD_P1L || ord == ORD_P3) ? PICK_C : PICK_B;
    endfunction

endpackage

// File: rtl/nan_order_chain.sv
module nan_order_chain
    import fma_nan_pkg::*;
#(
    parameter int ORD = 0
) (
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] cls_c,
    output logic [1:0] pick
);

    localparam logic [1:0] FALLBACK = fallback_of(ORD);

    logic [SLOTS-1:0] hit;
    logic [1:0]       slot_op [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam logic [3:0] RULE = slot_rule(ORD, i);
        localparam logic [1:0] TST  = RULE[3:2];
        localparam logic [1:0] OPN  = RULE[1:0];

        logic [1:0] cls_sel;
        assign cls_sel = (OPN == PICK_A) ? cls_a :
                         (OPN == PICK_B) ? cls_b : cls_c;

        assign hit[i] = (TST == TST_SIG)   ? (cls_sel == CLS_SIGNAL) :
                        (TST == TST_QUIET) ? (cls_sel == CLS_QUIET)  :
                        (TST == TST_ANY)   ? (cls_sel == CLS_QUIET || cls_sel == CLS_SIGNAL) :
                                             1'b0;
        assign slot_op[i] = OPN;
    end

    // lowest slot index has highest priority
    always_comb begin
        pick = FALLBACK;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit[i]) pick = slot_op[i];
        end
    end

endmodule

// File: rtl/nan_policy_sel.sv
module nan_policy_sel
    import fma_nan_pkg::*;
(
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] cls_c,
    input  logic       inf_zero,
    input  logic [1:0] policy,
    input  logic       legacy_enc,
    output logic [1:0] pick,
    output logic       invalid
);

    logic [1:0] ord_pick [N_ORDERS];

    for (genvar o = 0; o < N_ORDERS; o++) begin : g_ord
        nan_order_chain #(.ORD(o)) u_chain (
            .cls_a (cls_a),
            .cls_b (cls_b),
            .cls_c (cls_c),
            .pick  (ord_pick[o])
        );
    end

    // infinity-times-zero override is resolved before the chain result
    always_comb begin
        pick    = PICK_A;
        invalid = 1'b0;
        unique case (policy)
            2'd0: begin
                if (inf_zero && cls_c == CLS_QUIET) begin
                    pick    = PICK_DFLT;
                    invalid = 1'b1;
                end else begin
                    pick = ord_pick[ORD_P0];
                end
            end
            2'd1: begin
                if (inf_zero) begin
                    pick    = legacy_enc ? PICK_DFLT : PICK_C;
                    invalid = 1'b1;
                end else begin
                    pick = legacy_enc ? ord_pick[ORD_P1L] : ord_pick[ORD_P1N];
                end
            end
            2'd2: begin
                if (inf_zero) begin
                    pick    = PICK_C;
                    invalid = 1'b1;
                end else begin
                    pick = ord_pick[ORD_P2];
                end
            end
            default: begin
                pick = ord_pick[ORD_P3];
            end
        endcase
    end

endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
    import fma_nan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] cls_a,
    input  logic [1:0] cls_b,
    input  logic [1:0] cls_c,
    input  logic       inf_zero,
    input  logic [1:0] policy,
    input  logic       legacy_enc,
    output logic       out_valid,
    output logic [1:0] pick,
    output logic       invalid
);

    typedef enum logic {ST_IDLE, ST_EMIT} state_e;

    state_e     state_q, state_d;
    logic [1:0] pick_d, pick_q;
    logic       inv_d, inv_q;

    nan_policy_sel u_policy (
        .cls_a      (cls_a),
        .cls_b      (cls_b),
        .cls_c      (cls_c),
        .inf_zero   (inf_zero),
        .policy     (policy),
        .legacy_enc (legacy_enc),
        .pick       (pick_d),
        .invalid    (inv_d)
    );

    // transitions: T_ACCEPT, T_IDLE_WAIT, T_AGAIN, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pick_q <= PICK_A;
            inv_q  <= 1'b0;
        end else if (in_valid) begin
            pick_q <= pick_d;
            inv_q  <= inv_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign pick      = pick_q;
    assign invalid   = inv_q;

    assert_accept_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pick) && $stable(invalid)));
    assert_dflt_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pick == PICK_DFLT) |-> invalid);
    assert_p2_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd2 && inf_zero) |=> (invalid && pick == PICK_C));
    assert_p3_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && policy == 2'd3) |=> (!invalid && pick != PICK_DFLT));
    assert_inv_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inf_zero) |=> !invalid);

endmodule

// File: tb/tb_fma_nan_sel.sv
`timescale 1ns/1ps
module tb_fma_nan_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] cls_a = 2'd0, cls_b = 2'd0, cls_c = 2'd0;
    logic       inf_zero = 1'b0;
    logic [1:0] policy = 2'd0;
    logic       legacy_enc = 1'b0;
    logic       out_valid;
    logic [1:0] pick;
    logic       invalid;

    int n_checks = 0;
    int n_errors = 0;
    logic [1:0] last_pick = 2'd0;
    logic       last_inv  = 1'b0;

    typedef struct {
        logic [1:0] ch;
        logic       inv;
        int         req;
    } exp_t;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    fma_nan_sel dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
        .inf_zero(inf_zero), .policy(policy), .legacy_enc(legacy_enc),
        .out_valid(out_valid), .pick(pick), .invalid(invalid)
    );

    function automatic bit is_s(input logic [1:0] x); return x == 2'd2; endfunction
    function automatic bit is_q(input logic [1:0] x); return x == 2'd1; endfunction
    function automatic bit is_n(input logic [1:0] x); return x == 2'd1 || x == 2'd2; endfunction

    // reference model written from the requirements
    function automatic exp_t model(input logic [1:0] a, b, c, input logic iz,
                                   input logic [1:0] pol, input logic leg);
        exp_t e;
        e.inv = 1'b0;
        e.req = 0;
        if (pol == 2'd0) begin
            e.req = 3;                                  // R3
            if (iz && is_q(c)) begin e.ch = 3; e.inv = 1; e.req = 4; end   // R4
            else if (is_s(c)) e.ch = 2;
            else if (is_s(a)) e.ch = 0;
            else if (is_s(b)) e.ch = 1;
            else if (is_q(c)) e.ch = 2;
            else if (is_q(a)) e.ch = 0;
            else e.ch = 1;
            if (iz && !e.inv) e.req = 4;
        end else if (pol == 2'd1 && leg) begin
            e.req = iz ? 6 : 5;                         // R5 / R6
            if (iz) begin e.ch = 3; e.inv = 1; end
            else if (is_s(a)) e.ch = 0;
            else if (is_s(b)) e.ch = 1;
            else if (is_s(c)) e.ch = 2;
            else if (is_q(a)) e.ch = 0;
            else if (is_q(b)) e.ch = 1;
            else e.ch = 2;
        end else if (pol == 2'd1) begin
            e.req = iz ? 8 : 7;                         // R7 / R8
            if (iz) begin e.ch = 2; e.inv = 1; end
            else if (is_s(c)) e.ch = 2;
            else if (is_s(a)) e.ch = 0;
            else if (is_s(b)) e.ch = 1;
            else if (is_q(c)) e.ch = 2;
            else if (is_q(a)) e.ch = 0;
            else e.ch = 1;
        end else if (pol == 2'd2) begin
            e.req = 9;                                  // R9
            if (iz) begin e.ch = 2; e.inv = 1; end
            else if (is_n(a)) e.ch = 0;
            else if (is_n(c)) e.ch = 2;
            else e.ch = 1;
        end else begin
            e.req = 10;                                 // R10
            if (is_n(a)) e.ch = 0;
            else if (is_n(b)) e.ch = 1;
            else e.ch = 2;
        end
        if (a == 2'd3 || b == 2'd3 || c == 2'd3) e.req = 11;   // R11
        return e;
    endfunction

    task automatic send(input logic [1:0] a, b, c, input logic iz,
                        input logic [1:0] pol, input logic leg);
        sb.push_back(model(a, b, c, iz, pol, leg));
        in_valid = 1'b1; cls_a = a; cls_b = b; cls_c = c;
        inf_zero = iz; policy = pol; legacy_enc = leg;
        @(negedge clk);
    endtask

    // monitor: result due one edge after acceptance
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_checks++;
            if (sb.size() == 0) begin
                n_errors++;
                $display("FAIL R1: out_valid=1 with no pending request (expected 0)");
            end else begin
                e = sb.pop_front();
                if (pick !== e.ch || invalid !== e.inv) begin
                    n_errors++;
                    $display("FAIL R%0d: pick=%0d invalid=%0d expected pick=%0d invalid=%0d",
                             e.req, pick, invalid, e.ch, e.inv);
                end
                last_pick = e.ch;
                last_inv  = e.inv;
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not finish (expected completion)");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0 && pick === 2'd0 && invalid === 1'b0,
              $sformatf("R1 reset: out_valid=%0d pick=%0d invalid=%0d expected 0 0 0",
                        out_valid, pick, invalid));
        rst_n = 1'b1;
        @(negedge clk);

        // directed cases
        send(2'd1, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0);  // R3: b signaling beats quiet c -> b
        send(2'd0, 2'd0, 2'd1, 1'b1, 2'd0, 1'b0);  // R4: override -> default, invalid
        send(2'd0, 2'd0, 2'd2, 1'b1, 2'd0, 1'b0);  // R4: signaling c, no override -> c
        send(2'd1, 2'd2, 2'd2, 1'b0, 2'd1, 1'b1);  // R5: b signaling first -> b
        send(2'd0, 2'd0, 2'd0, 1'b1, 2'd1, 1'b1);  // R6: default, invalid
        send(2'd2, 2'd1, 2'd1, 1'b0, 2'd1, 1'b0);  // R7: a signaling beats quiet c -> a
        send(2'd1, 2'd1, 2'd0, 1'b1, 2'd1, 1'b0);  // R8: -> c, invalid
        send(2'd0, 2'd2, 2'd1, 1'b0, 2'd2, 1'b0);  // R9: c any NaN beats b -> c
        send(2'd0, 2'd1, 2'd2, 1'b1, 2'd3, 1'b0);  // R10: flag ignored -> b, no invalid
        send(2'd3, 2'd3, 2'd1, 1'b0, 2'd3, 1'b0);  // R11: code 3 is non-NaN -> c
        in_valid = 1'b0;
        @(negedge clk);

        // R2: outputs hold with in_valid low (stimulus changes meanwhile)
        cls_a = 2'd2; cls_b = 2'd2; cls_c = 2'd2; inf_zero = 1'b1; policy = 2'd0;
        repeat (3) @(negedge clk);
        check(pick === last_pick && invalid === last_inv,
              $sformatf("R2 hold: pick=%0d invalid=%0d expected %0d %0d",
                        pick, invalid, last_pick, last_inv));
        check(out_valid === 1'b0,
              $sformatf("R1 idle: out_valid=%0d expected 0", out_valid));

        // exhaustive sweep, back to back; R12 covered by every iz=0 entry
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 2; l++)
                for (int z = 0; z < 2; z++)
                    for (int v = 0; v < 64; v++)
                        send(v[1:0], v[3:2], v[5:4], z[0], p[1:0], l[0]);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0,
              $sformatf("R1 drain: pending=%0d expected 0", sb.size()));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule